// File: doc/BRIEF.md
# Packed SIMD Integer Multiplier

This block multiplies two 64-bit packed operands lane by lane and writes the products into a packed 64-bit result. The width of each source lane and each destination lane is chosen per operation. A destination lane may be wider than its source lane, which gives widening multiplies. A 6-bit mode word selects the behaviour:

- the lanes are read as signed or unsigned values;
- a rounding constant can be added before the high half is taken;
- the high half of the double-width product can be kept instead of the low half;
- for widening multiplies, the source lanes feeding destination lane i can be taken from the even or the odd narrow positions.

A scalar mode writes only lane 0. The other lanes then take their bits from the previous destination value, which the caller supplies. Every destination lane size has its own bank of lane multipliers, and all banks run in parallel. The selected bank's result is merged with the old destination and registered. A result therefore appears one clock after its operands are presented.

Top module: `simd_mul`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `result` is all zeros until the first accepted operation.
- R2: `out_valid` equals `in_valid` of the previous cycle, and `result` holds its value in every cycle that follows a cycle with `in_valid` low.
- R3: Lane sizes are coded 0, 1, 2 and 3 for 8, 16, 32 and 64 bits. With mode 0 and equal source and destination sizes, each of the 64/d destination lanes i holds the low d bits of the unsigned product of source lane i of `opnd_a` and source lane i of `opnd_b`.
- R4: With mode bit 1 set, both operands are sign-extended from the source lane width before the multiply. With it clear, both operands are zero-extended.
- R5: Mode bit 2 adds 2^(d-1) to the full 2d-bit product before any half is selected, where d is the destination lane width.
- R6: Mode bit 3 makes lane i take bits [2d-1:d] of the 2d-bit, possibly rounded, product. Without it, the lane takes bits [d-1:0].
- R7: With mode bit 4 set, destination lane i reads its source operands starting at bit i*d when mode bit 5 is set, and at bit i*d+s when mode bit 5 is clear, where s is the source width. Source bits above bit 63 read as zero.
- R8: With mode bit 4 clear and s smaller than d, destination lane i reads its source operands starting at bit i*s.
- R9: With mode bit 0 set, only destination lane 0 is computed. All bits above lane 0 equal `dst_old`.
- R10: When the source size code is larger than the destination size code, `result` equals `dst_old`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| opnd_a | input | 64 | First packed source |
| opnd_b | input | 64 | Second packed source |
| dst_old | input | 64 | Previous destination value, used for unwritten lanes |
| src_sz | input | 2 | Source lane size code (0..3 = 8..64 bits) |
| dst_sz | input | 2 | Destination lane size code (0..3 = 8..64 bits) |
| mode | input | 6 | Bit 0 scalar, 1 signed, 2 round, 3 high half, 4 lane pick, 5 even pick |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Registered packed result |

## Verification
The bench instantiates the block with its default 64-bit data width. At that width all four lane sizes are available, and every lane size has its own multiplier bank. Every one of the 16 size pairs is driven together with all 64 mode words, on five operand patterns. Those patterns include operands of all ones, of 0x80 lanes and of 0x7f lanes, which push signed and unsigned products, rounding carries and high halves to their extremes. The 64-bit destination lanes make the widest 128-bit products observable. The illegal size pairs reach the pass-through behaviour of R10.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  // Bit positions inside the mode word
  localparam int MB_SCALAR = 0;
  localparam int MB_SIGNED = 1;
  localparam int MB_ROUND  = 2;
  localparam int MB_HIGH   = 3;
  localparam int MB_PICK   = 4;
  localparam int MB_EVEN   = 5;
  localparam int MODE_W    = 6;
  localparam int SZ_W      = 2;
  localparam int BASE_BITS = 8;
endpackage

// File: rtl/simd_mul_pick.sv
// Extracts one operand for destination lane LANE and extends it to DW+1 bits.
module simd_mul_pick
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DW     = 8,
  parameter int LANE   = 0
) (
  input  logic [DATA_W-1:0] src,
  input  logic [SZ_W-1:0]   src_sz,
  input  logic              pick_en,
  input  logic              even_sel,
  input  logic              sgn,
  output logic [DW:0]       op
);
  localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

  int               sb;
  int               off;
  logic [DW-1:0]    raw;
  logic [DW-1:0]    msk;
  logic [IDX_W-1:0] top;
  logic             sbit;

  always_comb begin
    sb  = BASE_BITS << src_sz;
    off = pick_en ? (LANE * DW + (even_sel ? 0 : sb)) : (LANE * sb);
    raw = DW'({{DATA_W{1'b0}}, src} >> off);
    msk = (sb >= DW) ? {DW{1'b1}} : DW'((65'd1 << sb) - 65'd1);
    top = IDX_W'((sb > DW) ? (DW - 1) : (sb - 1));
    sbit = sgn & raw[top];
    op  = {sbit, (raw & msk) | (sbit ? ~msk : {DW{1'b0}})};
  end
endmodule

// File: rtl/simd_mul_lane.sv
// One lane: exact 2*DW product, optional rounding, half selection.
module simd_mul_lane #(
  parameter int DW = 8
) (
  input  logic [DW:0]   a,
  input  logic [DW:0]   b,
  input  logic          rnd_en,
  input  logic          high_sel,
  output logic [DW-1:0] res
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] ea;
  logic [PW-1:0] eb;
  logic [PW-1:0] prod;
  logic [PW-1:0] acc;

  always_comb begin
    ea   = {{(DW-1){a[DW]}}, a};
    eb   = {{(DW-1){b[DW]}}, b};
    prod = ea * eb;
    acc  = prod + (rnd_en ? (PW'(1) << (DW - 1)) : {PW{1'b0}});
    res  = high_sel ? acc[PW-1:DW] : acc[DW-1:0];
  end
endmodule

// File: rtl/simd_mul_bank.sv
// All lanes of one destination lane size.
module simd_mul_bank
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DW     = 8
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SZ_W-1:0]   src_sz,
  input  logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] packed_res
);
  localparam int LANES = DATA_W / DW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW:0]   op_a;
    logic [DW:0]   op_b;
    logic [DW-1:0] lane_res;

    simd_mul_pick #(.DATA_W(DATA_W), .DW(DW), .LANE(g)) u_pick_a (
      .src(opnd_a), .src_sz(src_sz), .pick_en(mode[MB_PICK]),
      .even_sel(mode[MB_EVEN]), .sgn(mode[MB_SIGNED]), .op(op_a)
    );
    simd_mul_pick #(.DATA_W(DATA_W), .DW(DW), .LANE(g)) u_pick_b (
      .src(opnd_b), .src_sz(src_sz), .pick_en(mode[MB_PICK]),
      .even_sel(mode[MB_EVEN]), .sgn(mode[MB_SIGNED]), .op(op_b)
    );
    simd_mul_lane #(.DW(DW)) u_lane (
      .a(op_a), .b(op_b), .rnd_en(mode[MB_ROUND]),
      .high_sel(mode[MB_HIGH]), .res(lane_res)
    );
    assign packed_res[g*DW +: DW] = lane_res;
  end
endmodule

// File: rtl/simd_mul.sv
module simd_mul
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [SZ_W-1:0]   src_sz,
  input  logic [SZ_W-1:0]   dst_sz,
  input  logic [MODE_W-1:0] mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NUM_SZ = $clog2(DATA_W / BASE_BITS) + 1;

  logic [DATA_W-1:0] bank_res [NUM_SZ];
  logic [DATA_W-1:0] full;
  logic [DATA_W-1:0] lane0_msk;
  logic [DATA_W-1:0] nxt;
  int                dbits;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_bank
    simd_mul_bank #(.DATA_W(DATA_W), .DW(BASE_BITS << k)) u_bank (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .src_sz(src_sz),
      .mode(mode), .packed_res(bank_res[k])
    );
  end

  always_comb begin
    full      = bank_res[dst_sz];
    dbits     = BASE_BITS << dst_sz;
    lane0_msk = (dbits >= DATA_W) ? {DATA_W{1'b1}}
                                  : DATA_W'((65'd1 << dbits) - 65'd1);
    if (src_sz > dst_sz)
      nxt = dst_old;
    else if (mode[MB_SCALAR])
      nxt = (full & lane0_msk) | (dst_old & ~lane0_msk);
    else
      nxt = full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        result <= nxt;
    end
  end
endmodule

// File: rtl/simd_mul_chk.sv
module simd_mul_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] dst_old,
  input logic [1:0]        src_sz,
  input logic [1:0]        dst_sz,
  input logic [5:0]        mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q && !rst)
      AST_IDLE_AFTER_RESET: assert (!out_valid && result == '0); // R1
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R2
  AST_SCALAR_UPPER: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[0] && src_sz == 2'd0 && dst_sz == 2'd0)
      |=> result[DATA_W-1:8] == $past(dst_old[DATA_W-1:8])); // R9
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && src_sz > dst_sz) |=> result == $past(dst_old)); // R10
endmodule

bind simd_mul simd_mul_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dst_old(dst_old),
  .src_sz(src_sz), .dst_sz(dst_sz), .mode(mode),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_simd_mul.sv
`timescale 1ns/1ps
module tb_simd_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0, dst_old = '0;
  logic [1:0]  src_sz = '0, dst_sz = '0;
  logic [5:0]  mode = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [63:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  simd_mul dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .dst_old(dst_old), .src_sz(src_sz), .dst_sz(dst_sz),
    .mode(mode), .out_valid(out_valid), .result(result)
  );

  // Reference model written from the requirements
  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
      logic [63:0] old, int ss, int ds, logic [5:0] m);
    int sbits, dbits, n, off;
    logic [127:0] xa, xb, fm;
    logic signed [129:0] va, vb, p;
    logic [63:0] r;
    r = old;
    if (ss > ds) return old;                       // R10
    sbits = 8 << ss;
    dbits = 8 << ds;
    n = m[0] ? 1 : 64 / dbits;                     // R9, R3
    fm = (128'd1 << sbits) - 128'd1;
    for (int i = 0; i < n; i++) begin
      if (m[4]) off = i * (dbits - sbits) + (m[5] ? 0 : sbits) + i * sbits; // R7
      else      off = i * sbits;                   // R8
      xa = ({64'd0, a} >> off) & fm;
      xb = ({64'd0, b} >> off) & fm;
      va = $signed({2'b00, xa});
      vb = $signed({2'b00, xb});
      if (m[1] && xa[sbits-1]) va = va - (130'sd1 <<< sbits); // R4
      if (m[1] && xb[sbits-1]) vb = vb - (130'sd1 <<< sbits);
      p = va * vb;
      if (m[2]) p = p + (130'sd1 <<< (dbits - 1)); // R5
      if (m[3]) p = p >>> dbits;                   // R6
      for (int j = 0; j < dbits; j++) r[i*dbits + j] = p[j];
    end
    return r;
  endfunction

  function automatic string pick_tag(int ss, int ds, logic [5:0] m);
    if (ss > ds) return "R10";
    if (m[0]) return "R9";
    if (m[4]) return "R7";
    if (m[3]) return "R6";
    if (m[2]) return "R5";
    if (m[1]) return "R4";
    if (ss < ds) return "R8";
    return "R3";
  endfunction

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [63:0] old,
                       int ss, int ds, logic [5:0] m);
    item_t it;
    @(negedge clk);
    opnd_a = a; opnd_b = b; dst_old = old;
    src_sz = 2'(ss); dst_sz = 2'(ds); mode = m; in_valid = 1'b1;
    it.exp = model(a, b, old, ss, ds, m);
    it.tag = pick_tag(ss, ds, m);
    sb_q.push_back(it);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      item_t it;
      n_run++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected out_valid, result=%h expected no output", result);
      end else begin
        it = sb_q.pop_front();
        if (result !== it.exp) begin
          n_fail++;
          $display("FAIL %s: result=%h expected=%h", it.tag, result, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa, pb, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      n_fail++;
      $display("FAIL R1: out_valid=%b result=%h expected 0/0", out_valid, result);
    end
    for (int p = 0; p < 5; p++)
      for (int ss = 0; ss < 4; ss++)
        for (int ds = 0; ds < 4; ds++)
          for (int m = 0; m < 64; m++) begin
            case (p)
              0: begin pa = {$urandom, $urandom}; pb = {$urandom, $urandom}; end
              1: begin pa = '1; pb = '1; end
              2: begin pa = {8{8'h80}}; pb = {8{8'h7f}}; end
              3: begin pa = {$urandom, $urandom}; pb = '1; end
              default: begin pa = 64'h0123456789abcdef; pb = 64'hfedcba9876543210; end
            endcase
            drive(pa, pb, {$urandom, $urandom}, ss, ds, 6'(m));
          end
    @(negedge clk);
    in_valid = 1'b0;
    opnd_a = '1; opnd_b = '1; mode = 6'd0;
    @(negedge clk);
    held = result;
    repeat (3) @(negedge clk);
    n_run++;
    if (result !== held || out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: idle result=%h valid=%b expected=%h valid=0", result, out_valid, held);
    end
    n_run++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule